// File: doc/BRIEF.md
# Digital Potentiometer Serial Control Slave

This block is the two-wire serial front end of a digitally controlled resistor with one or two channels. It samples the bus clock and data lines on the system clock, finds start and stop conditions, and answers only to its own 7-bit device address. The address is a fixed five-bit prefix followed by two strap pins. It drives the data line only through an open-drain pull-down enable.

A write transaction carries a bit-mapped command byte after the address. The command byte names a channel and carries a mid-scale request, a per-channel power-down request and two general-purpose output levels. Any number of data bytes may follow, and each one reuses the same command. The block hands the decoded command fields and each data byte to the register block as single-cycle strobes. A read transaction has no command byte. The slave shifts out the byte that the register block presents on its readback input, which is the code of the channel chosen by the most recent write, and it repeats for as long as the master keeps acknowledging.

The system clock must run at least eight times faster than the bus clock. Every bus event reaches the outputs `SYNC_STAGES + 1` system cycles after it appears on the pins.

Top module: `dpot_i2c_slave`

## Requirements
- R1: Out of reset the slave releases the data line (`sda_oe` = 0) and raises neither `cmd_valid` nor `data_valid`.
- R2: The slave acknowledges an address byte, by pulling the data line low during the ninth clock pulse, when its upper seven bits equal `01011` followed by `addr_pins[1]` and then `addr_pins[0]`. The least significant bit selects the direction: 0 is a write and 1 is a read. Bytes are sent most significant bit first.
- R3: After an address byte that does not match, the slave acknowledges nothing and raises no strobe until the next start condition.
- R4: The first byte after a write address is the command byte, decoded as bit 7 channel, bit 6 mid-scale, bit 5 power-down, bit 4 output one, bit 3 output two, with bits 2 to 0 ignored. The slave acknowledges it and raises `cmd_valid` for one cycle, exactly `SYNC_STAGES + 1` cycles after the rising clock edge of its eighth bit reaches `scl_i`.
- R5: Each byte after the command byte in a write is acknowledged and is presented on `data_byte` with a one-cycle `data_valid`, with the same latency as in R4.
- R6: The command fields stay at the values of the last command byte while all later data bytes of the transaction are delivered.
- R7: A write that stops right after the command byte still raises `cmd_valid` and raises no `data_valid`.
- R8: In a read the slave drives `rd_data` out most significant bit first, starting on the clock pulse after its address acknowledge. It reloads `rd_data` after each master acknowledge. After a master no-acknowledge it releases the data line and stays silent until the next start.
- R9: A start condition at any bit position abandons the byte in progress and decodes the following byte as an address.
- R10: A stop condition at any bit position returns the slave to idle. Clock pulses that follow without a start are neither acknowledged nor delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_pins | input | 2 | Strap pins forming the two low address bits |
| rd_data | input | 8 | Readback code from the register block |
| sda_oe | output | 1 | 1 pulls the data line low |
| cmd_valid | output | 1 | One-cycle strobe: new command fields |
| cmd_chan | output | 1 | Channel select from the command byte |
| cmd_mid | output | 1 | Mid-scale request |
| cmd_pdown | output | 1 | Power-down request for the selected channel |
| cmd_out1 | output | 1 | Level of general-purpose output one |
| cmd_out2 | output | 1 | Level of general-purpose output two |
| data_valid | output | 1 | One-cycle strobe: new data byte |
| data_byte | output | 8 | Received data byte |

## Verification
Each strobe is due exactly three system cycles (synchroniser depth plus one) after the bench raises the bus clock for the eighth bit of a byte. The bench stores that due time in a queue when it drives the edge and compares it with the instant the strobe appears, so a strobe that is early, late, missing or not expected is reported. The acknowledge and the read data change three cycles after a falling bus clock. The bench samples them four cycles into the following high phase, well after they have settled.

// File: rtl/dpot_i2c_pkg.sv
`timescale 1ns/1ps
package dpot_i2c_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int PIN_W     = 2;
    localparam int DEV_ADR_W = 7;
    localparam int PREFIX_W  = DEV_ADR_W - PIN_W;
    localparam logic [PREFIX_W-1:0] DEV_PREFIX = 5'b01011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_ACK_PEND,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_st_e;

    typedef struct packed {
        logic chan;
        logic mid;
        logic pdown;
        logic out1;
        logic out2;
    } cmd_t;

    function automatic cmd_t cmd_decode(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.chan  = b[7];
        c.mid   = b[6];
        c.pdown = b[5];
        c.out1  = b[4];
        c.out2  = b[3];
        return c;
    endfunction

    function automatic logic dev_match(input logic [DEV_ADR_W-1:0] adr,
                                       input logic [PIN_W-1:0] pins);
        return adr == {DEV_PREFIX, pins};
    endfunction

endpackage

// File: rtl/dpot_sync.sv
`timescale 1ns/1ps
module dpot_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dpot_bus_cond.sv
`timescale 1ns/1ps
module dpot_bus_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dpot_link.sv
`timescale 1ns/1ps
module dpot_link import dpot_i2c_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_valid,
    output cmd_t              cmd_q,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_q
);
    link_st_e             state, after_ack;
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    rx_sh, tx_sh, rx_byte;
    logic                 master_ack;

    assign rx_byte = {rx_sh[BYTE_W-2:0], sda_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_q      <= '0;
            data_valid <= 1'b0;
            data_q     <= '0;
        end else begin
            cmd_valid  <= 1'b0;
            data_valid <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh <= rx_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                                if (state == ST_ADDR) begin
                                    if (dev_match(rx_byte[BYTE_W-1:1], addr_pins)) begin
                                        state     <= ST_ACK_PEND;
                                        after_ack <= rx_byte[0] ? ST_TX : ST_CMD;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end else if (state == ST_CMD) begin
                                    cmd_q     <= cmd_decode(rx_byte);
                                    cmd_valid <= 1'b1;
                                    state     <= ST_ACK_PEND;
                                    after_ack <= ST_WDATA;
                                end else begin
                                    data_q     <= rx_byte;
                                    data_valid <= 1'b1;
                                    state      <= ST_ACK_PEND;
                                    after_ack  <= ST_WDATA;
                                end
                            end
                        end
                    end
                    ST_ACK_PEND: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_HOLD;
                        end
                    end
                    ST_ACK_HOLD: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (after_ack == ST_TX) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                            state <= after_ack;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                cnt    <= cnt + 1'b1;
                                sda_oe <= ~tx_sh[BYTE_W-2];
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_bit;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                cnt    <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: a stop leaves the slave idle with the line released
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det && !start_det |=> (state == ST_IDLE) && !sda_oe);

    // R9: a start resynchronises to the first address bit
    a_r9_start_resync: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_ADDR) && (cnt == '0) && !sda_oe);

    // R3: an unaddressed slave stays silent
    a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe && !cmd_valid && !data_valid);

    // R6: data bytes never disturb the held command
    a_r6_cmd_held: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $stable(cmd_q));

    // R8: the line is free while the master answers a read byte
    a_r8_master_ack_free: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK) |-> !sda_oe);
endmodule

// File: rtl/dpot_i2c_slave.sv
`timescale 1ns/1ps
module dpot_i2c_slave import dpot_i2c_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic              cmd_chan,
    output logic              cmd_mid,
    output logic              cmd_pdown,
    output logic              cmd_out1,
    output logic              cmd_out2,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_byte
);
    logic [1:0] lines_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    cmd_t       cmd_q;

    dpot_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines_s)
    );

    dpot_bus_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dpot_link u_link (
        .clk        (clk),
        .rst        (rst),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_bit    (lines_s[0]),
        .addr_pins  (addr_pins),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .cmd_valid  (cmd_valid),
        .cmd_q      (cmd_q),
        .data_valid (data_valid),
        .data_q     (data_byte)
    );

    assign cmd_chan  = cmd_q.chan;
    assign cmd_mid   = cmd_q.mid;
    assign cmd_pdown = cmd_q.pdown;
    assign cmd_out1  = cmd_q.out1;
    assign cmd_out2  = cmd_q.out2;
endmodule

// File: tb/dpot_i2c_slave_tb.sv
`timescale 1ns/1ps
module dpot_i2c_slave_tb;
    localparam realtime    CLK_P = 5.0;
    localparam int         LAT   = 3;
    localparam logic [1:0] PINS  = 2'b10;
    localparam logic [7:0] A_WR  = {5'b01011, PINS, 1'b0};
    localparam logic [7:0] A_RD  = {5'b01011, PINS, 1'b1};

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
    logic [7:0] rd_data = 8'h00;
    logic sda_i, sda_oe, cmd_valid, cmd_chan, cmd_mid, cmd_pdown, cmd_out1, cmd_out2;
    logic data_valid;
    logic [7:0] data_byte;

    assign sda_i = sda_m & ~sda_oe;
    always #(CLK_P / 2) clk = ~clk;

    dpot_i2c_slave u_dut (
        .clk (clk), .rst (rst), .scl_i (scl), .sda_i (sda_i),
        .addr_pins (PINS), .rd_data (rd_data), .sda_oe (sda_oe),
        .cmd_valid (cmd_valid), .cmd_chan (cmd_chan), .cmd_mid (cmd_mid),
        .cmd_pdown (cmd_pdown), .cmd_out1 (cmd_out1), .cmd_out2 (cmd_out2),
        .data_valid (data_valid), .data_byte (data_byte)
    );

    realtime    exp_t[$];
    int         exp_k[$];
    logic [7:0] exp_v[$];
    string      exp_r[$];
    int         n_cmp = 0, n_bad = 0;
    string      phase = "R1";
    logic [4:0] last_fields = 5'b0;
    bit         done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input logic [31:0] act,
                            input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pop_evt();
        void'(exp_t.pop_front());
        void'(exp_k.pop_front());
        void'(exp_v.pop_front());
        void'(exp_r.pop_front());
    endtask

    // Reference: every strobe is matched against the queue on every clock
    always @(negedge clk) begin
        int k;
        if (!rst && !done) begin
            if (exp_t.size() > 0 && $realtime > exp_t[0]) begin
                n_cmp++; n_bad++;
                $display("FAIL %s missing strobe: actual none expected kind %0d at %0t",
                         exp_r[0], exp_k[0], exp_t[0]);
                pop_evt();
            end
            if (cmd_valid || data_valid) begin
                if (exp_t.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL %s unexpected strobe: actual cmd=%0b data=%0b expected none",
                             phase, cmd_valid, data_valid);
                end else begin
                    k = cmd_valid ? 1 : 2;
                    n_cmp++;
                    if ($realtime != exp_t[0]) begin
                        n_bad++;
                        $display("FAIL %s strobe time: actual %0t expected %0t",
                                 exp_r[0], $realtime, exp_t[0]);
                    end
                    check_eq(exp_r[0], k, exp_k[0], "strobe kind");
                    if (k == 1) begin
                        check_eq(exp_r[0], {cmd_chan, cmd_mid, cmd_pdown, cmd_out1, cmd_out2},
                                 exp_v[0][7:3], "command fields");
                        last_fields = exp_v[0][7:3];
                    end else begin
                        check_eq(exp_r[0], data_byte, exp_v[0], "data byte");
                        check_eq("R6", {cmd_chan, cmd_mid, cmd_pdown, cmd_out1, cmd_out2},
                                 last_fields, "held fields");
                    end
                    pop_evt();
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL ALL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(4);
        scl = 1'b1;   tick(8);
        sda_m = 1'b0; tick(8);
        scl = 1'b0;   tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(4);
        scl = 1'b1;   tick(8);
        sda_m = 1'b1; tick(8);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;  tick(4);
        scl = 1'b1; tick(8);
        scl = 1'b0; tick(4);
    endtask

    // evk: 0 none, 1 command strobe, 2 data strobe
    task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                             input int evk, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(4);
            scl = 1'b1;
            if (i == 0 && evk != 0) begin
                exp_t.push_back($realtime + LAT * CLK_P);
                exp_k.push_back(evk);
                exp_v.push_back(b);
                exp_r.push_back(req);
            end
            tick(8);
            scl = 1'b0; tick(4);
        end
        sda_m = 1'b1; tick(4);
        scl = 1'b1;   tick(4);
        check_eq(req, {31'd0, ~sda_i}, {31'd0, exp_ack}, "acknowledge");
        tick(4);
        scl = 1'b0;   tick(4);
    endtask

    task automatic read_byte(input logic [7:0] expv, input logic [7:0] nxt,
                             input logic m_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(4);
            scl = 1'b1;   tick(4);
            check_eq(req, {31'd0, sda_i}, {31'd0, expv[i]}, "read bit");
            tick(4);
            scl = 1'b0;   tick(4);
        end
        rd_data = nxt;
        put_bit(~m_ack);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        check_eq("R1", {31'd0, sda_oe}, 0, "sda_oe after reset");
        check_eq("R1", {31'd0, cmd_valid}, 0, "cmd_valid after reset");
        check_eq("R1", {31'd0, data_valid}, 0, "data_valid after reset");

        // R2 R4 R5 R6: command then three data bytes
        phase = "R5";
        bus_start();
        send_byte(A_WR, 1'b1, 0, "R2");
        send_byte(8'hB0, 1'b1, 1, "R4");
        send_byte(8'h37, 1'b1, 2, "R5");
        send_byte(8'hC4, 1'b1, 2, "R6");
        send_byte(8'h00, 1'b1, 2, "R6");
        bus_stop();

        // R7: stop right after the command byte
        phase = "R7";
        bus_start();
        send_byte(A_WR, 1'b1, 0, "R2");
        send_byte(8'h48, 1'b1, 1, "R7");
        bus_stop();
        tick(10);
        check_eq("R7", exp_t.size(), 0, "pending strobes");

        // R3: other address on the bus
        phase = "R3";
        bus_start();
        send_byte({5'b01011, 2'b11, 1'b0}, 1'b0, 0, "R3");
        send_byte(8'h90, 1'b0, 0, "R3");
        send_byte(8'h12, 1'b0, 0, "R3");
        bus_stop();

        // R8: two reads, acknowledged then not acknowledged
        phase = "R8";
        rd_data = 8'hA6;
        bus_start();
        send_byte(A_RD, 1'b1, 0, "R2");
        read_byte(8'hA6, 8'h3B, 1'b1, "R8");
        read_byte(8'h3B, 8'h3B, 1'b0, "R8");
        tick(2);
        check_eq("R8", {31'd0, sda_oe}, 0, "line after no-acknowledge");
        bus_stop();

        // R9: repeated start in the middle of an address byte
        phase = "R9";
        bus_start();
        for (int i = 7; i >= 4; i--) put_bit(A_WR[i]);
        bus_start();
        send_byte(A_WR, 1'b1, 0, "R9");
        send_byte(8'h10, 1'b1, 1, "R9");
        send_byte(8'h99, 1'b1, 2, "R9");
        bus_stop();

        // R10: stop in the middle of a command byte, then clocks without start
        phase = "R10";
        bus_start();
        send_byte(A_WR, 1'b1, 0, "R10");
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_stop();
        scl = 1'b0; tick(4);
        send_byte(A_WR, 1'b0, 0, "R10");
        send_byte(8'h10, 1'b0, 0, "R10");
        bus_stop();
        bus_start();
        send_byte(A_WR, 1'b1, 0, "R10");
        send_byte(8'h08, 1'b1, 1, "R4");
        bus_stop();

        tick(20);
        check_eq("R5", exp_t.size(), 0, "strobes left undelivered");
        finish_run();
    end
endmodule